// File: doc/BRIEF.md
# Edge-Triggered Timestamp Capture Unit

This block takes a snapshot of externally supplied time and date values when a chosen edge appears on an asynchronous trigger pin. The trigger is first brought into the bus clock domain and then passed to an edge detector. A select bit chooses whether a rising or a falling transition counts as an event. On an accepted event the current `time_in` and `date_in` buses are latched into holding registers, and a timestamp flag goes high.

A small state machine owns the timestamp flag. It has three states:
- `ST_EMPTY`: no capture is held.
- `ST_HELD`: a capture is held and flagged.
- `ST_CLR_PEND`: software has asked for a clear, and the flag is still visible while the delay runs out.

The transitions are named as follows:
- `EV_CAPTURE` takes `ST_EMPTY` to `ST_HELD`.
- `CLEAR_REQ` takes `ST_HELD` to `ST_CLR_PEND`.
- `CLEAR_DONE` takes `ST_CLR_PEND` back to `ST_EMPTY` once `CLR_DELAY` cycles have passed.

An event that arrives while the flag is visible raises a sticky overflow flag. Such an event leaves the first capture untouched.

Software clears either flag by writing 0 to its bit with `flag_wr` high. Writing 1 to a bit leaves that flag as it is. The overflow flag clears at the next edge. The timestamp flag clears only after the delayed clear has completed.

Top module: `ts_stamp_unit`

## Requirements
- R1: After reset both flags are 0 and both capture registers hold 0.
- R2: With `edge_sel`=0 and `cap_en`=1, a 0-to-1 change on `trig_in` while the timestamp flag is 0 latches `time_in` and `date_in`. The timestamp flag and the captured values appear after the third rising clock edge following the change, and not after the second.
- R3: With `edge_sel`=1, a 1-to-0 change on `trig_in` is the event, and a 0-to-1 change has no effect. With `edge_sel`=0, a 1-to-0 change has no effect.
- R4: An event that occurs while the timestamp flag is 1 sets the overflow flag. It leaves `cap_time` and `cap_date` unchanged.
- R5: `flag_wdata` bit 0 is the timestamp flag and bit 1 is the overflow flag. A write with bit 1 = 0 clears the overflow flag at the next edge, unless an event occurs at that same edge. A bit written as 1 leaves its flag unchanged.
- R6: A write with bit 0 = 0, sampled at edge k while the timestamp flag is set, leaves the flag reading 1 after edges k and k+1. The flag reads 0 after edge k+2.
- R7: An event that lands inside the clear window of R6 sets the overflow flag and does not capture. The pending clear still completes on time.
- R8: While `cap_en` is 0, trigger edges cause no capture and change neither flag. Capture works again once `cap_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 1 | Asynchronous trigger pin |
| edge_sel | input | 1 | 0 selects a rising trigger edge, 1 selects a falling trigger edge |
| cap_en | input | 1 | Capture enable |
| time_in | input | TIME_W | Current time value |
| date_in | input | DATE_W | Current date value |
| flag_wr | input | 1 | Flag write strobe, one cycle |
| flag_wdata | input | 2 | Write data: bit 0 for the timestamp flag, bit 1 for the overflow flag; 0 clears the flag |
| cap_time | output | TIME_W | Latched time |
| cap_date | output | DATE_W | Latched date |
| ts_flag | output | 1 | Timestamp flag |
| ovf_flag | output | 1 | Overflow flag |

## Verification
The bench builds the unit with its defaults: 24-bit time and date buses, a two-stage synchroniser and a clear delay of two cycles. These values fix the trigger-to-flag latency at three edges, so the bench can place an event exactly inside the two-cycle clear window. The full-width buses let all-ones and sign-bit patterns show that no capture bit is dropped or overwritten.

// File: rtl/ts_stamp_pkg.sv
package ts_stamp_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY    = 2'd0,
        ST_HELD     = 2'd1,
        ST_CLR_PEND = 2'd2
    } ts_state_e;

    localparam int FLAG_TS_BIT  = 0;
    localparam int FLAG_OVF_BIT = 1;
    localparam int FLAG_W       = 2;

endpackage

// File: rtl/ts_sync.sv
module ts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ts_edge_det.sv
module ts_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic edge_sel,
    input  logic enable,
    output logic event_o
);
    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    always_comb begin
        rise    = level & ~prev_q;
        fall    = ~level & prev_q;
        event_o = enable & (edge_sel ? fall : rise);
    end
endmodule

// File: rtl/ts_hold_reg.sv
module ts_hold_reg #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/ts_flag_fsm.sv
module ts_flag_fsm
    import ts_stamp_pkg::*;
#(
    parameter int CLR_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              event_i,
    input  logic              flag_wr,
    input  logic [FLAG_W-1:0] flag_wdata,
    output logic              capture,
    output logic              ts_flag,
    output logic              ovf_flag,
    output ts_state_e         state
);
    localparam int CW = (CLR_DELAY < 2) ? 1 : $clog2(CLR_DELAY);
    localparam logic [CW-1:0] CNT_LAST = CW'(CLR_DELAY - 1);

    ts_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic ovf_q, ovf_d;
    logic clr_ts_req;
    logic clr_ovf_req;

    assign clr_ts_req  = flag_wr & ~flag_wdata[FLAG_TS_BIT];
    assign clr_ovf_req = flag_wr & ~flag_wdata[FLAG_OVF_BIT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ovf_q   <= ovf_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ovf_d   = ovf_q;
        capture = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (event_i) begin          // EV_CAPTURE
                    capture = 1'b1;
                    state_d = ST_HELD;
                end
                if (clr_ovf_req) ovf_d = 1'b0;
            end
            ST_HELD: begin
                if (clr_ts_req) begin       // CLEAR_REQ
                    state_d = ST_CLR_PEND;
                    cnt_d   = '0;
                end
                if (event_i)          ovf_d = 1'b1;
                else if (clr_ovf_req) ovf_d = 1'b0;
            end
            ST_CLR_PEND: begin
                if (cnt_q == CNT_LAST) begin // CLEAR_DONE
                    state_d = ST_EMPTY;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
                if (event_i)          ovf_d = 1'b1;
                else if (clr_ovf_req) ovf_d = 1'b0;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    assign ts_flag  = (state_q != ST_EMPTY);
    assign ovf_flag = ovf_q;
    assign state    = state_q;
endmodule

// File: rtl/ts_stamp_unit.sv
module ts_stamp_unit
    import ts_stamp_pkg::*;
#(
    parameter int TIME_W      = 24,
    parameter int DATE_W      = 24,
    parameter int SYNC_STAGES = 2,
    parameter int CLR_DELAY   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              edge_sel,
    input  logic              cap_en,
    input  logic [TIME_W-1:0] time_in,
    input  logic [DATE_W-1:0] date_in,
    input  logic              flag_wr,
    input  logic [FLAG_W-1:0] flag_wdata,
    output logic [TIME_W-1:0] cap_time,
    output logic [DATE_W-1:0] cap_date,
    output logic              ts_flag,
    output logic              ovf_flag
);
    logic      trig_sync;
    logic      trig_event;
    logic      do_capture;
    ts_state_e fsm_state;

    ts_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (trig_in),
        .dout  (trig_sync)
    );

    ts_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (trig_sync),
        .edge_sel (edge_sel),
        .enable   (cap_en),
        .event_o  (trig_event)
    );

    ts_flag_fsm #(.CLR_DELAY(CLR_DELAY)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .event_i    (trig_event),
        .flag_wr    (flag_wr),
        .flag_wdata (flag_wdata),
        .capture    (do_capture),
        .ts_flag    (ts_flag),
        .ovf_flag   (ovf_flag),
        .state      (fsm_state)
    );

    ts_hold_reg #(.WIDTH(TIME_W)) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (do_capture),
        .d     (time_in),
        .q     (cap_time)
    );

    ts_hold_reg #(.WIDTH(DATE_W)) u_date (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (do_capture),
        .d     (date_in),
        .q     (cap_date)
    );
endmodule

// File: rtl/ts_stamp_chk.sv
module ts_stamp_chk
    import ts_stamp_pkg::*;
#(
    parameter int TIME_W = 24,
    parameter int DATE_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_en,
    input logic [TIME_W-1:0] time_in,
    input logic [DATE_W-1:0] date_in,
    input logic              flag_wr,
    input logic [FLAG_W-1:0] flag_wdata,
    input logic [TIME_W-1:0] cap_time,
    input logic [DATE_W-1:0] cap_date,
    input logic              ts_flag,
    input logic              ovf_flag,
    input logic              trig_event,
    input ts_state_e         fsm_state
);
    assert_capture_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ts_flag) |-> (cap_time == $past(time_in)) && (cap_date == $past(date_in)));

    assert_hold_while_flagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ts_flag |=> $stable(cap_time) && $stable(cap_date));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag && !trig_event) |=> !ovf_flag);

    assert_ovf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_wdata[FLAG_OVF_BIT] && !trig_event) |=> !ovf_flag);

    assert_clear_delayed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_wdata[FLAG_TS_BIT] && fsm_state == ST_HELD) |=> ts_flag);

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !ts_flag) |=> !ts_flag);
endmodule

bind ts_stamp_unit ts_stamp_chk #(.TIME_W(TIME_W), .DATE_W(DATE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_en     (cap_en),
    .time_in    (time_in),
    .date_in    (date_in),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .cap_time   (cap_time),
    .cap_date   (cap_date),
    .ts_flag    (ts_flag),
    .ovf_flag   (ovf_flag),
    .trig_event (trig_event),
    .fsm_state  (fsm_state)
);

// File: tb/tb_ts_stamp_unit.sv
`timescale 1ns/1ps
module tb_ts_stamp_unit;
    localparam int TW = 24;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_in = 1'b0;
    logic          edge_sel = 1'b0;
    logic          cap_en = 1'b1;
    logic [TW-1:0] time_in = '0;
    logic [DW-1:0] date_in = '0;
    logic          flag_wr = 1'b0;
    logic [1:0]    flag_wdata = 2'b11;
    logic [TW-1:0] cap_time;
    logic [DW-1:0] cap_date;
    logic          ts_flag;
    logic          ovf_flag;

    ts_stamp_unit dut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .edge_sel(edge_sel),
        .cap_en(cap_en), .time_in(time_in), .date_in(date_in),
        .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .cap_time(cap_time), .cap_date(cap_date),
        .ts_flag(ts_flag), .ovf_flag(ovf_flag)
    );

    always #5 clk = ~clk;

    typedef struct {
        int            when;
        logic [TW-1:0] t;
        logic [DW-1:0] d;
        logic          ts;
        logic          ovf;
        string         req;
    } exp_t;

    exp_t q[$];
    exp_t it;
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares queued expectations at their cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].when <= cyc) begin
            it = q.pop_front();
            checks++;
            if (cap_time !== it.t || cap_date !== it.d ||
                ts_flag !== it.ts || ovf_flag !== it.ovf) begin
                errors++;
                $display("FAIL %s cyc=%0d actual t=%h d=%h ts=%b ovf=%b expected t=%h d=%h ts=%b ovf=%b",
                    it.req, cyc, cap_time, cap_date, ts_flag, ovf_flag,
                    it.t, it.d, it.ts, it.ovf);
            end
        end
    end

    task automatic expect_in(int dly, logic [TW-1:0] t, logic [DW-1:0] d,
                             logic ts, logic ovf, string req);
        exp_t e;
        e.when = cyc + dly; e.t = t; e.d = d; e.ts = ts; e.ovf = ovf; e.req = req;
        q.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [23:0] A = 24'h123456, B = 24'h0A0B0C, C = 24'hFFFFFF;
    localparam logic [23:0] D = 24'h800001, E = 24'h7FFFFE, F = 24'h55AAAA;
    localparam logic [23:0] G = 24'hC33C00, H = 24'h000F0F;

    initial begin
        tick(3);
        rst_n = 1'b1;
        expect_in(1, '0, '0, 1'b0, 1'b0, "R1");
        tick(2);

        // R2 rising capture and latency
        time_in = A; date_in = B; trig_in = 1'b1;
        expect_in(2, '0, '0, 1'b0, 1'b0, "R2");
        expect_in(3, A, B, 1'b1, 1'b0, "R2");
        tick(4);

        // R3 falling ignored with edge_sel=0
        time_in = C; date_in = C; trig_in = 1'b0;
        expect_in(4, A, B, 1'b1, 1'b0, "R3");
        tick(5);

        // R4 second event while flagged
        trig_in = 1'b1;
        expect_in(3, A, B, 1'b1, 1'b1, "R4");
        tick(4);

        // R5 writing ones has no effect
        flag_wr = 1'b1; flag_wdata = 2'b11;
        expect_in(2, A, B, 1'b1, 1'b1, "R5");
        tick(1); flag_wr = 1'b0; tick(3);

        // R5/R6 clear both: overflow at next edge, timestamp two edges later
        flag_wr = 1'b1; flag_wdata = 2'b00;
        expect_in(1, A, B, 1'b1, 1'b0, "R5");
        expect_in(2, A, B, 1'b1, 1'b0, "R6");
        expect_in(3, A, B, 1'b0, 1'b0, "R6");
        tick(1); flag_wr = 1'b0; flag_wdata = 2'b11; tick(4);

        // R3 falling edge with edge_sel=1
        edge_sel = 1'b1; time_in = D; date_in = E; trig_in = 1'b0;
        expect_in(3, D, E, 1'b1, 1'b0, "R3");
        tick(4);
        trig_in = 1'b1;
        expect_in(4, D, E, 1'b1, 1'b0, "R3");
        tick(5);

        // R7 event inside clear window
        time_in = F; date_in = F; trig_in = 1'b0;
        expect_in(3, D, E, 1'b1, 1'b1, "R7");
        expect_in(4, D, E, 1'b0, 1'b1, "R7");
        tick(1);
        flag_wr = 1'b1; flag_wdata = 2'b10;
        tick(1); flag_wr = 1'b0; flag_wdata = 2'b11;
        tick(4);

        // clear overflow only
        flag_wr = 1'b1; flag_wdata = 2'b01;
        expect_in(1, D, E, 1'b0, 1'b0, "R5");
        tick(1); flag_wr = 1'b0; flag_wdata = 2'b11; tick(2);

        // R8 disabled: no capture, no flags
        cap_en = 1'b0; trig_in = 1'b1;
        tick(4);
        trig_in = 1'b0;
        expect_in(4, D, E, 1'b0, 1'b0, "R8");
        tick(5);

        // R8 re-enabled capture works
        cap_en = 1'b1; time_in = G; date_in = H; trig_in = 1'b1;
        tick(4);
        trig_in = 1'b0;
        expect_in(3, G, H, 1'b1, 1'b0, "R8");
        tick(6);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule